// File: doc/BRIEF.md
# Write-Only I2C Control Register Slave

This block is an I2C-bus target that only accepts write transfers and uses them to load a bank of eight 8-bit control registers for an audio processor. The bank holds two volume registers, three control registers and three alignment registers. SCL and SDA are first passed through two-flop synchronizers. START and STOP are detected from the synchronized lines. After a START the block compares the first byte with a fixed 7-bit device address and a write direction bit. The next byte selects a register, and every byte after that is data.

Each accepted byte is acknowledged by pulling SDA low for one clock pulse. The first data byte goes to the selected register. Each later byte goes to the next location. Between the volume pair and the control group, the location numbering has three unused slots. A master that streams bytes across that point must therefore send three filler bytes, and the block drops them. All eight registers are available in parallel on one flat output bus.

Top module: `ctl_i2c_wslave`

## Requirements
- R1: After synchronous reset every register reads 00h and `sda_oe` is 0 (SDA released).
- R2: A first byte of 1011011 followed by direction bit 0 (B6h on the wire, MSB first) is acknowledged, and the transfer that follows writes registers.
- R3: After a first byte with any other 7-bit address, the block acknowledges nothing and writes nothing until the next START or repeated START.
- R4: A first byte carrying the correct address with direction bit 1 (B7h) is not acknowledged, and the rest of the transfer is ignored.
- R5: The register-select byte and every data byte of a matched transfer are acknowledged, with SDA driven low only while SCL is low or during the acknowledge clock.
- R6: Register-select values map to the bank as follows: 00h volume right (bank bits 7:0), 01h volume left (15:8), 05h control 1 (23:16), 06h control 2 (31:24), 07h control 3 (39:32), 08h alignment 1 (47:40), 09h alignment 2 (55:48), 0Ah alignment 3 (63:56). A single data byte goes to the register that was selected.
- R7: Each further data byte in the same transfer goes to the location after the previous one, counting up by one.
- R8: Data bytes that land on locations 02h to 04h during auto-increment are dropped, so a stream starting at 00h needs three filler bytes between volume left and control 1.
- R9: Bit 7 of both volume registers always reads 0. Only bits 6:0 are stored.
- R10: A register-select value outside the mapped set is still acknowledged. Its data is dropped, and auto-increment continues from that value.
- R11: A repeated START restarts address matching, whether the earlier address matched or not.
- R12: A STOP, including one in the middle of a byte, returns the receiver to idle and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| bank_o | output | 64 | Eight registers, register n at bits 8n+7:8n |

## Verification
The bench goes after the filler gap in the auto-increment path. A decoder that maps locations linearly would put the three filler bytes into control 1 to control 3 and shift every later register. Unmapped locations, the read direction bit and foreign addresses are also driven. A design that does not gate its acknowledge would ACK them, and one that does not block its writes would corrupt the bank. Repeated STARTs are sent after both a matched and a foreign address, and a STOP is cut into the middle of a data byte. These catch a receiver that keeps stale address state or that commits a partial byte.

// File: rtl/wrslv_pkg.sv
package wrslv_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK_SETUP,
        RX_ACK_HOLD,
        RX_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        FLD_ADDR,
        FLD_SUB,
        FLD_DATA
    } field_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] idx;
    } slot_t;

    // Locations below low_cnt map straight to slots; a second group starts at high_base.
    function automatic slot_t slot_lookup(input logic [7:0] sub, input int low_cnt,
                                          input int high_base, input int nreg);
        slot_t r;
        int    s;
        s     = int'(sub);
        r.hit = 1'b0;
        r.idx = '0;
        if (s < low_cnt) begin
            r.hit = 1'b1;
            r.idx = sub;
        end else if (s >= high_base && s < high_base + nreg - low_cnt) begin
            r.hit = 1'b1;
            r.idx = 8'(s - high_base + low_cnt);
        end
        return r;
    endfunction

endpackage

// File: rtl/wrslv_sync.sv
module wrslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d          = sy_q;
        sy_d.scl_sh   = {sy_q.scl_sh[STAGES-2:0], scl_in};
        sy_d.sda_sh   = {sy_q.sda_sh[STAGES-2:0], sda_in};
        sy_d.scl_prev = sy_q.scl_sh[MSB];
        sy_d.sda_prev = sy_q.sda_sh[MSB];
    end

    always_ff @(posedge clk) begin
        if (rst) sy_q <= '1;
        else     sy_q <= sy_d;
    end

    assign scl_s     = sy_q.scl_sh[MSB];
    assign sda_s     = sy_q.sda_sh[MSB];
    assign scl_rise  = scl_s & ~sy_q.scl_prev;
    assign scl_fall  = ~scl_s & sy_q.scl_prev;
    assign start_det = scl_s & sy_q.scl_prev & sy_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sy_q.scl_prev & ~sy_q.sda_prev & sda_s;

endmodule

// File: rtl/wrslv_rx.sv
module wrslv_rx
    import wrslv_pkg::*;
#(
    parameter int         DW       = 8,
    parameter logic [6:0] DEV_ADDR = 7'h5B
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [DW-1:0] wr_ptr,
    output logic [DW-1:0] wr_data
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
    localparam logic [DW-1:0] MATCH_BYTE = DW'({DEV_ADDR, 1'b0});

    typedef struct packed {
        rx_state_e     state;
        field_e        field;
        logic [CW-1:0] bitcnt;
        logic [DW-1:0] shreg;
        logic [DW-1:0] ptr;
        logic          oe;
        logic          wr_en;
        logic [DW-1:0] wr_ptr;
        logic [DW-1:0] wr_data;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [DW-1:0] byte_in;

    assign byte_in = {rx_q.shreg[DW-2:0], sda_s};

    always_comb begin
        rx_d       = rx_q;
        rx_d.wr_en = 1'b0;
        if (stop_det) begin
            rx_d.state = RX_IDLE;
            rx_d.oe    = 1'b0;
        end else if (start_det) begin
            rx_d.state  = RX_SHIFT;
            rx_d.field  = FLD_ADDR;
            rx_d.bitcnt = '0;
            rx_d.oe     = 1'b0;
        end else begin
            unique case (rx_q.state)
                RX_SHIFT: if (scl_rise) begin
                    rx_d.shreg = byte_in;
                    if (rx_q.bitcnt == LAST_BIT) begin
                        rx_d.bitcnt = '0;
                        rx_d.state  = RX_ACK_SETUP;
                        unique case (rx_q.field)
                            FLD_ADDR: if (byte_in != MATCH_BYTE) rx_d.state = RX_SKIP;
                            FLD_SUB:  rx_d.ptr = byte_in;
                            default: begin
                                rx_d.wr_en   = 1'b1;
                                rx_d.wr_ptr  = rx_q.ptr;
                                rx_d.wr_data = byte_in;
                                rx_d.ptr     = rx_q.ptr + 1'b1;
                            end
                        endcase
                    end else begin
                        rx_d.bitcnt = rx_q.bitcnt + 1'b1;
                    end
                end
                RX_ACK_SETUP: if (scl_fall) begin
                    rx_d.oe    = 1'b1;
                    rx_d.state = RX_ACK_HOLD;
                end
                RX_ACK_HOLD: if (scl_fall) begin
                    rx_d.oe    = 1'b0;
                    rx_d.state = RX_SHIFT;
                    rx_d.field = (rx_q.field == FLD_ADDR) ? FLD_SUB : FLD_DATA;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q       <= '0;
            rx_q.state <= RX_IDLE;
            rx_q.field <= FLD_ADDR;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sda_oe  = rx_q.oe;
    assign wr_en   = rx_q.wr_en;
    assign wr_ptr  = rx_q.wr_ptr;
    assign wr_data = rx_q.wr_data;

endmodule

// File: rtl/wrslv_bank.sv
module wrslv_bank
    import wrslv_pkg::*;
#(
    parameter int DW        = 8,
    parameter int NREG      = 8,
    parameter int LOW_CNT   = 2,
    parameter int HIGH_BASE = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_ptr,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] bank_o
);
    logic [NREG-1:0][DW-1:0] regs_d, regs_q;
    logic [NREG-1:0][DW-1:0] keep_mask;
    slot_t                   sel;

    // Narrow (volume) slots store only the low DW-1 bits.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g < LOW_CNT) begin : g_narrow
            assign keep_mask[g] = {1'b0, {(DW-1){1'b1}}};
        end else begin : g_full
            assign keep_mask[g] = '1;
        end
        assign bank_o[g*DW +: DW] = regs_q[g];
    end

    always_comb begin
        regs_d = regs_q;
        sel    = slot_lookup(8'(wr_ptr), LOW_CNT, HIGH_BASE, NREG);
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && sel.hit && sel.idx == 8'(i))
                regs_d[i] = wr_data & keep_mask[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

endmodule

// File: rtl/ctl_i2c_wslave.sv
module ctl_i2c_wslave #(
    parameter int         DW          = 8,
    parameter int         NREG        = 8,
    parameter int         LOW_CNT     = 2,
    parameter int         HIGH_BASE   = 5,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h5B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [NREG*DW-1:0] bank_o
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [DW-1:0] wr_ptr, wr_data;

    wrslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    wrslv_rx #(.DW(DW), .DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data)
    );

    wrslv_bank #(.DW(DW), .NREG(NREG), .LOW_CNT(LOW_CNT), .HIGH_BASE(HIGH_BASE)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
        .bank_o(bank_o)
    );

endmodule

// File: rtl/ctl_i2c_wslave_chk.sv
module ctl_i2c_wslave_chk #(
    parameter int DW        = 8,
    parameter int NREG      = 8,
    parameter int LOW_CNT   = 2,
    parameter int HIGH_BASE = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_s,
    input logic               sda_oe,
    input logic               stop_det,
    input logic               wr_en,
    input logic [DW-1:0]      wr_ptr,
    input logic [NREG*DW-1:0] bank_o
);
    localparam int MAP_END = HIGH_BASE + NREG - LOW_CNT;

    AST_ACK_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);                                        // R5

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);                                            // R12

    AST_STOP_KEEPS_BANK: assert property (@(posedge clk) disable iff (rst)
        (stop_det && !wr_en) |=> $stable(bank_o));                        // R12

    AST_GAP_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_ptr) >= LOW_CNT && int'(wr_ptr) < HIGH_BASE)
        |=> $stable(bank_o));                                             // R8

    AST_UNMAPPED_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_ptr) >= MAP_END) |=> $stable(bank_o));          // R10

    for (genvar g = 0; g < LOW_CNT; g++) begin : g_vol
        AST_VOL_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
            !bank_o[g*DW + DW - 1]);                                      // R9
    end

endmodule

bind ctl_i2c_wslave ctl_i2c_wslave_chk #(
    .DW(DW), .NREG(NREG), .LOW_CNT(LOW_CNT), .HIGH_BASE(HIGH_BASE)
) u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .stop_det(stop_det),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .bank_o(bank_o)
);

// File: tb/ctl_i2c_wslave_test.sv
module ctl_i2c_wslave_test;
    localparam int Q = 8;

    typedef struct {
        logic [63:0] bank;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [63:0] bank_o;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    logic [7:0] model [8];
    logic [7:0] cur_ptr;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    ctl_i2c_wslave uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .bank_o(bank_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    waitq();
        scl_m = 1'b1; waitq(); waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic put_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic ack;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        ack = ~sda_line;
        waitq();
        scl_m = 1'b0; waitq();
        check(ack == exp_ack, req, 64'(ack), 64'(exp_ack));
    endtask

    // Reference map from the requirements: 00h,01h volumes; 05h..0Ah control/alignment.
    task automatic model_write(input logic [7:0] loc, input logic [7:0] d);
        if (loc == 8'h00)      model[0] = d & 8'h7F;
        else if (loc == 8'h01) model[1] = d & 8'h7F;
        else if (loc >= 8'h05 && loc <= 8'h0A) model[loc - 8'h03] = d;
    endtask

    task automatic push_expect(input string tag);
        exp_t e;
        for (int i = 0; i < 8; i++) e.bank[i*8 +: 8] = model[i];
        e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic write_seq(input logic [7:0] sub, input logic [7:0] data[$], input string req);
        put_byte(8'hB6, 1'b1, "R2");
        put_byte(sub, 1'b1, "R5");
        cur_ptr = sub;
        foreach (data[k]) begin
            put_byte(data[k], 1'b1, "R5");
            model_write(cur_ptr, data[k]);
            cur_ptr = cur_ptr + 1'b1;
        end
    endtask

    task automatic xfer(input logic [7:0] sub, input logic [7:0] data[$], input string req);
        bus_start();
        write_seq(sub, data, req);
        bus_stop();
        push_expect(req);
    endtask

    // Monitor: compares the bank against the scoreboard queue.
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            repeat (4) @(negedge clk);
            check(bank_o == exp_q[0].bank, exp_q[0].tag, bank_o, exp_q[0].bank);
            void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(bank_o == 64'h0, "R1", bank_o, 64'h0);
        check(sda_oe == 1'b0, "R1", 64'(sda_oe), 64'h0);

        xfer(8'h00, '{8'h35}, "R6 single to volume right");
        xfer(8'h01, '{8'hFF}, "R9 volume left bit7 cleared");
        xfer(8'h08, '{8'hA5}, "R6 single to alignment 1");

        xfer(8'h00, '{8'h91, 8'h22, 8'hD1, 8'hD2, 8'hD3, 8'h33, 8'h44, 8'h55,
                      8'h66, 8'h77, 8'h88}, "R8 R7 full stream with filler");
        xfer(8'h05, '{8'h9A, 8'h9B}, "R7 increment from control 1");
        xfer(8'h0B, '{8'h5A, 8'h5B}, "R10 unmapped location dropped");
        xfer(8'h03, '{8'hE1, 8'hE2, 8'hC7}, "R10 increment continues from gap");
        xfer(8'hFF, '{8'h11, 8'h6C}, "R10 wrap from FFh");

        // R3: foreign address, nothing acknowledged or written
        bus_start();
        put_byte(8'hB4, 1'b0, "R3");
        put_byte(8'h00, 1'b0, "R3");
        put_byte(8'hEE, 1'b0, "R3");
        check(sda_oe == 1'b0, "R3", 64'(sda_oe), 64'h0);
        bus_stop();
        push_expect("R3 foreign address ignored");

        // R4: read direction refused
        bus_start();
        put_byte(8'hB7, 1'b0, "R4");
        put_byte(8'h06, 1'b0, "R4");
        put_byte(8'h13, 1'b0, "R4");
        bus_stop();
        push_expect("R4 read direction ignored");

        // R11: repeated START after a matched and after a foreign address
        bus_start();
        write_seq(8'h06, '{8'h42}, "R11");
        bus_start();
        put_byte(8'h40, 1'b0, "R11");
        put_byte(8'h00, 1'b0, "R11");
        put_byte(8'h99, 1'b0, "R11");
        bus_start();
        write_seq(8'h01, '{8'h12}, "R11");
        bus_stop();
        push_expect("R11 repeated start");

        // R12: STOP in the middle of a data byte
        bus_start();
        put_byte(8'hB6, 1'b1, "R12");
        put_byte(8'h00, 1'b1, "R12");
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        check(sda_oe == 1'b0, "R12", 64'(sda_oe), 64'h0);
        push_expect("R12 stop mid byte");
        xfer(8'h0A, '{8'h3C}, "R12 next transfer after stop");

        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule